// File: doc/BRIEF.md
# Central Job Allocation Arbiter

This block is the single point of control that hands out parallel work in a machine built from several processing elements (PEs), each hosting a fixed number of reducer agents and a bounded local heap. When a reducer reaches a point where its work can be split, it sends one request holding the whole family of candidate jobs: for each job a valid flag, a kind (fork or join), a home PE, a size in graph nodes and a root pointer. The requester stays blocked until the reply arrives, so the sizes it reported cannot change while the arbiter decides.

The arbiter keeps two resource tables: a bitmap of free reducers and a free-node counter per PE. It walks the candidate jobs one decision per cycle in priority order. A job is granted only when a PE has both a free reducer and room for the job's graph; a join job may only be placed on its home PE. Each grant debits storage, claims the reducer and emits a transport command in the next cycle. Jobs that cannot be placed are refused; no transport is issued for them and the requester evaluates that work itself. After the last decision a reply with a per-job grant mask and per-job PE number is raised for one cycle.

When a busy reducer announces its result, the arbiter frees that reducer, credits back the storage recorded at grant time and issues a return transport towards the reducer that requested the job.

Top module: `jaa_arbiter`

## Requirements
- R1: During and directly after reset, `req_ready` is 1, `rep_valid`, `xfer_valid` and `ret_valid` are 0, every reducer is free and every PE has `CAP` free nodes.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both 1; `req_ready` is 0 from the cycle after acceptance until the reply cycle, and `req_valid` pulses while `req_ready` is 0 have no effect on any output.
- R3: A job is granted only if the chosen PE has a free reducer and at least the job's size in free nodes; the size is debited from that PE in the grant cycle, and a job larger than `CAP` is always refused.
- R4: A refused job has its bit clear in `rep_grant` and produces no `xfer_valid` pulse; a reply whose `rep_grant` is all zero is a full refusal.
- R5: Pending jobs are decided one per cycle: every fork job (`req_job_fork` bit = 1) before any join job, within a class larger size first, equal sizes in lower job index first; the `xfer_valid` pulse for a granted job appears in the cycle after its decision and carries its root pointer and the requester's reducer number.
- R6: A fork job goes to the lowest-numbered PE that fits; on that PE the lowest free reducer is used. Reducer number = PE × `RED_PER_PE` + local index; `rep_pe` holds job i's PE in bits [i×PE_W +: PE_W].
- R7: A join job (`req_job_fork` bit = 0) is placed only on its home PE (`req_job_home` field i) and is refused if that PE cannot take it.
- R8: For a request with N valid jobs accepted at clock edge k, `rep_valid` is 1 for exactly one cycle, after edge k+N+1; an empty request is replied at edge k+1.
- R9: `res_valid` naming a busy reducer frees it, credits its granted size back to its PE and produces one `ret_valid` pulse in the next cycle with `ret_root` = `res_root`, `ret_src` = that reducer and `ret_dst` = the reducer that requested the job; a result naming a free reducer is ignored.
- R10: A PE's free-node count never exceeds `CAP` and never goes negative, so a job exactly filling the remaining space is granted and one more node is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Job family request strobe |
| req_ready | output | 1 | Arbiter idle, request can be taken |
| req_src | input | RID_W | Reducer number of the requester |
| req_job_valid | input | MAX_JOBS | Candidate job present, one bit per job |
| req_job_fork | input | MAX_JOBS | 1 = fork job, 0 = join job |
| req_job_home | input | MAX_JOBS×PE_W | Home PE of each job (binding for joins) |
| req_job_size | input | MAX_JOBS×SIZE_W | Graph size of each job in nodes |
| req_job_root | input | MAX_JOBS×PTR_W | Root pointer of each job |
| rep_valid | output | 1 | Reply strobe, one cycle |
| rep_grant | output | MAX_JOBS | Per-job grant mask |
| rep_pe | output | MAX_JOBS×PE_W | PE assigned to each granted job |
| xfer_valid | output | 1 | Job transport command strobe |
| xfer_root | output | PTR_W | Root pointer of the job to move |
| xfer_pe | output | PE_W | Destination PE |
| xfer_rid | output | RID_W | Destination reducer |
| xfer_src | output | RID_W | Reducer that requested the job |
| res_valid | input | 1 | Result-available strobe |
| res_rid | input | RID_W | Reducer announcing its result |
| res_root | input | PTR_W | Root pointer of the result graph |
| ret_valid | output | 1 | Result transport command strobe |
| ret_root | output | PTR_W | Root pointer of the result |
| ret_src | output | RID_W | Producing reducer |
| ret_dst | output | RID_W | Reducer that receives the result |

## Verification
On every cycle the assertions check that a grant never lands on a busy reducer or on a PE with too little room, that joins stay on their home PE, that no join is picked while a fork is pending, that free-node counters stay within capacity, and that grants and busy-reducer results are followed by their transport pulses. Only the bench scenarios show the exact grant masks and PE numbers, the decision order through the sequence of transported roots, the reply latency for empty and full families, the exact-fit storage boundary, and that stray requests and results for free reducers leave every output untouched.

// File: rtl/jaa_pkg.sv
// Shared types for the job allocation arbiter.
package jaa_pkg;

    // Arbiter control state: waiting for a request, or deciding jobs.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ALLOC = 1'b1
    } jaa_state_e;

endpackage

// File: rtl/jaa_pick.sv
// Priority selector over the pending candidate jobs.
// Picks fork jobs before join jobs, a larger size before a smaller one,
// and the lower index on a tie. Purely combinational.
// Assumes: sizes are packed with job i at bits [i*SIZE_W +: SIZE_W].
module jaa_pick #(
    parameter int MAX_JOBS = 4,
    parameter int SIZE_W   = 8,
    parameter int JIDX_W   = 2
) (
    input  logic [MAX_JOBS-1:0]        pending,
    input  logic [MAX_JOBS-1:0]        is_fork,
    input  logic [MAX_JOBS*SIZE_W-1:0] sizes,
    output logic                       sel_valid,
    output logic [JIDX_W-1:0]          sel_idx
);

    logic              best_fork;
    logic [SIZE_W-1:0] best_size;

    // Linear scan keeping the best candidate seen so far.
    always_comb begin
        sel_valid = 1'b0;
        sel_idx   = '0;
        best_fork = 1'b0;
        best_size = '0;
        for (int i = 0; i < MAX_JOBS; i++) begin
            if (pending[i]) begin
                if (!sel_valid
                    || (is_fork[i] && !best_fork)
                    || ((is_fork[i] == best_fork)
                        && (sizes[i*SIZE_W +: SIZE_W] > best_size))) begin
                    sel_valid = 1'b1;
                    sel_idx   = JIDX_W'(i);
                    best_fork = is_fork[i];
                    best_size = sizes[i*SIZE_W +: SIZE_W];
                end
            end
        end
    end

endmodule

// File: rtl/jaa_place.sv
// Placement finder: chooses the lowest-numbered PE that has a free reducer
// and enough free nodes for the job (a join may only use its home PE), and
// the lowest free reducer on that PE. Purely combinational.
// Assumes: reducer r of PE p has number p*RED_PER_PE + r.
module jaa_place #(
    parameter int NUM_PE     = 4,
    parameter int RED_PER_PE = 2,
    parameter int SIZE_W     = 8,
    parameter int CAP_W      = 8,
    parameter int PE_W       = 2,
    parameter int RID_W      = 3
) (
    input  logic [SIZE_W-1:0]         job_size,
    input  logic                      job_fork,
    input  logic [PE_W-1:0]           job_home,
    input  logic [NUM_PE*RED_PER_PE-1:0] red_free,
    input  logic [NUM_PE*CAP_W-1:0]   store_free,
    output logic                      ok,
    output logic [PE_W-1:0]           pe,
    output logic [RID_W-1:0]          rid
);

    localparam int RPP_W = (RED_PER_PE > 1) ? $clog2(RED_PER_PE) : 1;
    localparam int CW    = ((CAP_W > SIZE_W) ? CAP_W : SIZE_W) + 1;

    logic [NUM_PE-1:0] fit;
    logic [RID_W-1:0]  cand_rid [NUM_PE];

    for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
        logic             has_red;
        logic [RPP_W-1:0] red_idx;

        // Lowest free reducer on this PE.
        always_comb begin
            has_red = 1'b0;
            red_idx = '0;
            for (int r = RED_PER_PE - 1; r >= 0; r--) begin
                if (red_free[p*RED_PER_PE + r]) begin
                    has_red = 1'b1;
                    red_idx = RPP_W'(r);
                end
            end
        end

        // This PE can take the job: reducer, room, and home rule for joins.
        assign fit[p] = has_red
                      && (CW'(store_free[p*CAP_W +: CAP_W]) >= CW'(job_size))
                      && (job_fork || (job_home == PE_W'(p)));
        assign cand_rid[p] = RID_W'(p * RED_PER_PE) + RID_W'(red_idx);
    end

    // Lowest-numbered fitting PE wins.
    always_comb begin
        ok  = 1'b0;
        pe  = '0;
        rid = '0;
        for (int p = NUM_PE - 1; p >= 0; p--) begin
            if (fit[p]) begin
                ok  = 1'b1;
                pe  = PE_W'(p);
                rid = cand_rid[p];
            end
        end
    end

endmodule

// File: rtl/jaa_tables.sv
// Resource tables: free-reducer bitmap, per-PE free-node counters, and per
// reducer the granted size and the requester to return the result to.
// A grant and a result are applied in the same cycle when both occur.
// Assumes: a grant only targets a free reducer with enough room on its PE.
module jaa_tables #(
    parameter int NUM_PE     = 4,
    parameter int RED_PER_PE = 2,
    parameter int SIZE_W     = 8,
    parameter int CAP        = 200,
    parameter int CAP_W      = 8,
    parameter int PE_W       = 2,
    parameter int RID_W      = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         grant,
    input  logic [PE_W-1:0]              g_pe,
    input  logic [RID_W-1:0]             g_rid,
    input  logic [SIZE_W-1:0]            g_size,
    input  logic [RID_W-1:0]             g_parent,
    input  logic                         res_valid,
    input  logic [RID_W-1:0]             res_rid,
    output logic [NUM_PE*RED_PER_PE-1:0] red_free,
    output logic [NUM_PE*CAP_W-1:0]      store_free,
    output logic                         res_busy,
    output logic [RID_W-1:0]             res_parent
);

    localparam int NRED = NUM_PE * RED_PER_PE;

    logic [SIZE_W-1:0] size_of   [NRED];
    logic [RID_W-1:0]  parent_of [NRED];
    logic [CAP_W-1:0]  store     [NUM_PE];

    // A result only counts when it names a reducer that holds a job.
    assign res_busy   = res_valid && (int'(res_rid) < NRED) && !red_free[res_rid];
    assign res_parent = parent_of[res_rid];

    // Free-reducer bitmap: claimed on grant, released on result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            red_free <= '1;
        end else begin
            if (grant)    red_free[g_rid]   <= 1'b0;
            if (res_busy) red_free[res_rid] <= 1'b1;
        end
    end

    // Per-reducer record of the granted size and the requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NRED; i++) begin
                size_of[i]   <= '0;
                parent_of[i] <= '0;
            end
        end else if (grant) begin
            size_of[g_rid]   <= g_size;
            parent_of[g_rid] <= g_parent;
        end
    end

    for (genvar p = 0; p < NUM_PE; p++) begin : g_store
        logic [CAP_W-1:0] credit, debit;

        // Amounts returned by a result and taken by a grant on this PE.
        always_comb begin
            credit = (res_busy && (int'(res_rid) / RED_PER_PE == p))
                   ? CAP_W'(size_of[res_rid]) : '0;
            debit  = (grant && (g_pe == PE_W'(p))) ? CAP_W'(g_size) : '0;
        end

        // Free-node counter, both adjustments in one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) store[p] <= CAP_W'(CAP);
            else        store[p] <= store[p] + credit - debit;
        end

        assign store_free[p*CAP_W +: CAP_W] = store[p];
    end

endmodule

// File: rtl/jaa_arbiter.sv
// Central job allocation arbiter. Accepts one family of candidate jobs,
// decides one job per cycle in priority order, grants it when a PE has a
// free reducer and room (joins only on their home PE), issues a transport
// command per grant and a reply with grant mask and PEs at the end.
// Result announcements free the reducer, credit storage and issue a return
// transport. Assumes: the requester stays blocked until rep_valid.
module jaa_arbiter #(
    parameter int NUM_PE     = 4,
    parameter int RED_PER_PE = 2,
    parameter int MAX_JOBS   = 4,
    parameter int SIZE_W     = 8,
    parameter int PTR_W      = 16,
    parameter int CAP        = 200,
    localparam int NRED   = NUM_PE * RED_PER_PE,
    localparam int PE_W   = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
    localparam int RID_W  = (NRED > 1) ? $clog2(NRED) : 1,
    localparam int JIDX_W = (MAX_JOBS > 1) ? $clog2(MAX_JOBS) : 1,
    localparam int CAP_W  = $clog2(CAP + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [RID_W-1:0]           req_src,
    input  logic [MAX_JOBS-1:0]        req_job_valid,
    input  logic [MAX_JOBS-1:0]        req_job_fork,
    input  logic [MAX_JOBS*PE_W-1:0]   req_job_home,
    input  logic [MAX_JOBS*SIZE_W-1:0] req_job_size,
    input  logic [MAX_JOBS*PTR_W-1:0]  req_job_root,
    output logic                       rep_valid,
    output logic [MAX_JOBS-1:0]        rep_grant,
    output logic [MAX_JOBS*PE_W-1:0]   rep_pe,
    output logic                       xfer_valid,
    output logic [PTR_W-1:0]           xfer_root,
    output logic [PE_W-1:0]            xfer_pe,
    output logic [RID_W-1:0]           xfer_rid,
    output logic [RID_W-1:0]           xfer_src,
    input  logic                       res_valid,
    input  logic [RID_W-1:0]           res_rid,
    input  logic [PTR_W-1:0]           res_root,
    output logic                       ret_valid,
    output logic [PTR_W-1:0]           ret_root,
    output logic [RID_W-1:0]           ret_src,
    output logic [RID_W-1:0]           ret_dst
);
    import jaa_pkg::*;

    jaa_state_e                 state;
    logic [RID_W-1:0]           src_q;
    logic [MAX_JOBS-1:0]        pending, fork_q, grant_q;
    logic [MAX_JOBS*PE_W-1:0]   home_q, pe_q;
    logic [MAX_JOBS*SIZE_W-1:0] size_q;
    logic [MAX_JOBS*PTR_W-1:0]  root_q;

    logic                       sel_valid, sel_fork;
    logic [JIDX_W-1:0]          sel_idx;
    logic [SIZE_W-1:0]          sel_size;
    logic [PE_W-1:0]            sel_home;
    logic                       place_ok, grant;
    logic [PE_W-1:0]            place_pe;
    logic [RID_W-1:0]           place_rid;
    logic [NRED-1:0]            red_free;
    logic [NUM_PE*CAP_W-1:0]    store_free;
    logic                       res_busy;
    logic [RID_W-1:0]           res_parent;

    jaa_pick #(
        .MAX_JOBS (MAX_JOBS),
        .SIZE_W   (SIZE_W),
        .JIDX_W   (JIDX_W)
    ) u_pick (
        .pending   (pending),
        .is_fork   (fork_q),
        .sizes     (size_q),
        .sel_valid (sel_valid),
        .sel_idx   (sel_idx)
    );

    assign sel_fork = fork_q[sel_idx];
    assign sel_size = size_q[sel_idx*SIZE_W +: SIZE_W];
    assign sel_home = home_q[sel_idx*PE_W +: PE_W];

    jaa_place #(
        .NUM_PE     (NUM_PE),
        .RED_PER_PE (RED_PER_PE),
        .SIZE_W     (SIZE_W),
        .CAP_W      (CAP_W),
        .PE_W       (PE_W),
        .RID_W      (RID_W)
    ) u_place (
        .job_size   (sel_size),
        .job_fork   (sel_fork),
        .job_home   (sel_home),
        .red_free   (red_free),
        .store_free (store_free),
        .ok         (place_ok),
        .pe         (place_pe),
        .rid        (place_rid)
    );

    assign grant = (state == ST_ALLOC) && sel_valid && place_ok;

    jaa_tables #(
        .NUM_PE     (NUM_PE),
        .RED_PER_PE (RED_PER_PE),
        .SIZE_W     (SIZE_W),
        .CAP        (CAP),
        .CAP_W      (CAP_W),
        .PE_W       (PE_W),
        .RID_W      (RID_W)
    ) u_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant      (grant),
        .g_pe       (place_pe),
        .g_rid      (place_rid),
        .g_size     (sel_size),
        .g_parent   (src_q),
        .res_valid  (res_valid),
        .res_rid    (res_rid),
        .red_free   (red_free),
        .store_free (store_free),
        .res_busy   (res_busy),
        .res_parent (res_parent)
    );

    assign req_ready = (state == ST_IDLE);
    assign rep_grant = grant_q;
    assign rep_pe    = pe_q;

    // Request capture, per-cycle decision bookkeeping and reply strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            src_q     <= '0;
            pending   <= '0;
            fork_q    <= '0;
            home_q    <= '0;
            size_q    <= '0;
            root_q    <= '0;
            grant_q   <= '0;
            pe_q      <= '0;
            rep_valid <= 1'b0;
        end else begin
            rep_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        src_q   <= req_src;
                        pending <= req_job_valid;
                        fork_q  <= req_job_fork;
                        home_q  <= req_job_home;
                        size_q  <= req_job_size;
                        root_q  <= req_job_root;
                        grant_q <= '0;
                        pe_q    <= '0;
                        state   <= ST_ALLOC;
                    end
                end
                default: begin
                    if (sel_valid) begin
                        pending[sel_idx] <= 1'b0;
                        if (place_ok) begin
                            grant_q[sel_idx]              <= 1'b1;
                            pe_q[sel_idx*PE_W +: PE_W]    <= place_pe;
                        end
                    end else begin
                        rep_valid <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Job transport command, one cycle after the grant decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_valid <= 1'b0;
            xfer_root  <= '0;
            xfer_pe    <= '0;
            xfer_rid   <= '0;
            xfer_src   <= '0;
        end else begin
            xfer_valid <= grant;
            if (grant) begin
                xfer_root <= root_q[sel_idx*PTR_W +: PTR_W];
                xfer_pe   <= place_pe;
                xfer_rid  <= place_rid;
                xfer_src  <= src_q;
            end
        end
    end

    // Result return command, one cycle after a valid result announcement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_valid <= 1'b0;
            ret_root  <= '0;
            ret_src   <= '0;
            ret_dst   <= '0;
        end else begin
            ret_valid <= res_busy;
            if (res_busy) begin
                ret_root <= res_root;
                ret_src  <= res_rid;
                ret_dst  <= res_parent;
            end
        end
    end

endmodule

// File: rtl/jaa_arbiter_chk.sv
// Property checker for jaa_arbiter, attached with bind below.
// Observes the selector, placement and table signals of the arbiter.
module jaa_arbiter_chk #(
    parameter int NUM_PE     = 4,
    parameter int RED_PER_PE = 2,
    parameter int MAX_JOBS   = 4,
    parameter int SIZE_W     = 8,
    parameter int CAP        = 200,
    localparam int NRED   = NUM_PE * RED_PER_PE,
    localparam int PE_W   = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
    localparam int RID_W  = (NRED > 1) ? $clog2(NRED) : 1,
    localparam int CAP_W  = $clog2(CAP + 1),
    localparam int CW     = ((CAP_W > SIZE_W) ? CAP_W : SIZE_W) + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    grant,
    input logic [PE_W-1:0]         place_pe,
    input logic [RID_W-1:0]        place_rid,
    input logic [SIZE_W-1:0]       sel_size,
    input logic                    sel_valid,
    input logic                    sel_fork,
    input logic [PE_W-1:0]         sel_home,
    input logic [MAX_JOBS-1:0]     pending,
    input logic [MAX_JOBS-1:0]     fork_q,
    input logic [NRED-1:0]         red_free,
    input logic [NUM_PE*CAP_W-1:0] store_free,
    input logic                    req_ready,
    input logic                    rep_valid,
    input logic                    xfer_valid,
    input logic                    res_busy,
    input logic                    ret_valid
);

    assert_grant_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (red_free[place_rid]
                   && (CW'(store_free[place_pe*CAP_W +: CAP_W]) >= CW'(sel_size))));

    assert_grant_then_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> xfer_valid);

    assert_fork_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !sel_fork) |-> ((pending & fork_q) == '0));

    assert_join_home_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !sel_fork) |-> (place_pe == sel_home));

    assert_reply_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |-> req_ready);

    assert_reply_after_alloc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |-> $past(!req_ready));

    assert_result_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_busy |=> ret_valid);

    for (genvar p = 0; p < NUM_PE; p++) begin : g_cap
        assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
            store_free[p*CAP_W +: CAP_W] <= CAP_W'(CAP));
    end

endmodule

bind jaa_arbiter jaa_arbiter_chk #(
    .NUM_PE     (NUM_PE),
    .RED_PER_PE (RED_PER_PE),
    .MAX_JOBS   (MAX_JOBS),
    .SIZE_W     (SIZE_W),
    .CAP        (CAP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .place_pe   (place_pe),
    .place_rid  (place_rid),
    .sel_size   (sel_size),
    .sel_valid  (sel_valid),
    .sel_fork   (sel_fork),
    .sel_home   (sel_home),
    .pending    (pending),
    .fork_q     (fork_q),
    .red_free   (red_free),
    .store_free (store_free),
    .req_ready  (req_ready),
    .rep_valid  (rep_valid),
    .xfer_valid (xfer_valid),
    .res_busy   (res_busy),
    .ret_valid  (ret_valid)
);

// File: tb/sim_jaa_arbiter.sv
// Bench for jaa_arbiter: a behavioural reference model advanced on every
// rising edge and compared with the outputs on every falling edge, plus
// directed scenarios with hand-derived grant masks.
module sim_jaa_arbiter;
    localparam int NUM_PE = 4, RPP = 2, MJ = 4, SW = 8, PW = 16, CAP = 200;
    localparam int NRED = NUM_PE * RPP, PEW = 2, RIDW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [RIDW-1:0] req_src = '0;
    logic [MJ-1:0] req_job_valid = '0, req_job_fork = '0;
    logic [MJ*PEW-1:0] req_job_home = '0;
    logic [MJ*SW-1:0] req_job_size = '0;
    logic [MJ*PW-1:0] req_job_root = '0;
    logic rep_valid, xfer_valid, ret_valid;
    logic [MJ-1:0] rep_grant;
    logic [MJ*PEW-1:0] rep_pe;
    logic [PW-1:0] xfer_root, ret_root;
    logic [PEW-1:0] xfer_pe;
    logic [RIDW-1:0] xfer_rid, xfer_src, ret_src, ret_dst;
    logic res_valid = 1'b0;
    logic [RIDW-1:0] res_rid = '0;
    logic [PW-1:0] res_root = '0;

    jaa_arbiter #(.NUM_PE(NUM_PE), .RED_PER_PE(RPP), .MAX_JOBS(MJ),
                  .SIZE_W(SW), .PTR_W(PW), .CAP(CAP)) u0 (.*);

    always #4 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    // Reference model state.
    int  m_free[NRED], m_store[NUM_PE], m_sz[NRED], m_par[NRED];
    bit  m_busy;
    int  jf[MJ], jh[MJ], js[MJ], jr[MJ], m_pe[MJ];
    bit  m_pend[MJ], m_mask[MJ];
    int  m_src;
    bit  e_ready, e_rep, e_xv, e_retv;
    int  e_xpe, e_xrid, e_xroot, e_xsrc, e_rroot, e_rsrc, e_rdst;
    bit  e_mask[MJ];
    int  e_pe[MJ];

    // Staging for directed requests.
    int t_v[MJ], t_f[MJ], t_h[MJ], t_s[MJ], t_r[MJ];

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic model_reset();
        for (int i = 0; i < NRED; i++) begin m_free[i] = 1; m_sz[i] = 0; m_par[i] = 0; end
        for (int p = 0; p < NUM_PE; p++) m_store[p] = CAP;
        m_busy = 0; e_ready = 1; e_rep = 0; e_xv = 0; e_retv = 0;
        for (int i = 0; i < MJ; i++) begin m_pend[i] = 0; m_mask[i] = 0; end
    endtask

    task automatic model_step();
        bit rb;
        int best;
        rb = res_valid && (m_free[res_rid] == 0);
        e_xv = 0; e_rep = 0; e_retv = 0;
        if (m_busy) begin
            best = -1;
            for (int i = 0; i < MJ; i++)
                if (m_pend[i] && (best < 0 || (jf[i] == 1 && jf[best] == 0)
                    || (jf[i] == jf[best] && js[i] > js[best]))) best = i;
            if (best < 0) begin
                e_rep = 1; m_busy = 0;
                for (int i = 0; i < MJ; i++) begin e_mask[i] = m_mask[i]; e_pe[i] = m_pe[i]; end
            end else begin
                int fp, fr;
                fp = -1; fr = -1;
                m_pend[best] = 0;
                for (int p = 0; p < NUM_PE && fp < 0; p++)
                    if ((jf[best] == 1 || jh[best] == p) && m_store[p] >= js[best])
                        for (int r = 0; r < RPP && fp < 0; r++)
                            if (m_free[p*RPP + r] == 1) begin fp = p; fr = p*RPP + r; end
                if (fp >= 0) begin
                    m_free[fr] = 0; m_store[fp] -= js[best];
                    m_sz[fr] = js[best]; m_par[fr] = m_src;
                    m_mask[best] = 1; m_pe[best] = fp;
                    e_xv = 1; e_xpe = fp; e_xrid = fr; e_xroot = jr[best]; e_xsrc = m_src;
                end
            end
        end else if (req_valid) begin
            m_busy = 1; m_src = req_src;
            for (int i = 0; i < MJ; i++) begin
                m_pend[i] = req_job_valid[i]; m_mask[i] = 0; m_pe[i] = 0;
                jf[i] = req_job_fork[i]; jh[i] = req_job_home[i*PEW +: PEW];
                js[i] = req_job_size[i*SW +: SW]; jr[i] = req_job_root[i*PW +: PW];
            end
        end
        if (rb) begin
            m_free[res_rid] = 1; m_store[res_rid / RPP] += m_sz[res_rid];
            e_retv = 1; e_rroot = res_root; e_rsrc = res_rid; e_rdst = m_par[res_rid];
        end
        e_ready = !m_busy;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 req_ready", req_ready, e_ready);
            chk("R8 rep_valid", rep_valid, e_rep);
            if (e_rep) for (int i = 0; i < MJ; i++) begin
                chk("R4 rep_grant bit", rep_grant[i], e_mask[i]);
                if (e_mask[i]) chk("R6 rep_pe", rep_pe[i*PEW +: PEW], e_pe[i]);
            end
            chk("R3 xfer_valid", xfer_valid, e_xv);
            if (e_xv) begin
                chk("R6 xfer_pe", xfer_pe, e_xpe);
                chk("R6 xfer_rid", xfer_rid, e_xrid);
                chk("R5 xfer_root order", xfer_root, e_xroot);
                chk("R5 xfer_src", xfer_src, e_xsrc);
            end
            chk("R9 ret_valid", ret_valid, e_retv);
            if (e_retv) begin
                chk("R9 ret_root", ret_root, e_rroot);
                chk("R9 ret_src", ret_src, e_rsrc);
                chk("R9 ret_dst", ret_dst, e_rdst);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            errors++;
            $display("FAIL R2 watchdog: actual %0d cycles expected below 50000", cyc);
            finish_up();
        end
    end

    task automatic clear_jobs();
        for (int i = 0; i < MJ; i++) begin t_v[i] = 0; t_f[i] = 0; t_h[i] = 0; t_s[i] = 0; t_r[i] = 0; end
    endtask

    task automatic set_job(int i, int f, int h, int s, int r);
        t_v[i] = 1; t_f[i] = f; t_h[i] = h; t_s[i] = s; t_r[i] = r;
    endtask

    task automatic send(int src);
        while (!req_ready) @(negedge clk);
        req_src = RIDW'(src);
        for (int i = 0; i < MJ; i++) begin
            req_job_valid[i] = t_v[i][0];
            req_job_fork[i]  = t_f[i][0];
            req_job_home[i*PEW +: PEW] = PEW'(t_h[i]);
            req_job_size[i*SW +: SW]   = SW'(t_s[i]);
            req_job_root[i*PW +: PW]   = PW'(t_r[i]);
        end
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rep(output int n, output logic [MJ-1:0] mask);
        n = 0;
        do begin @(negedge clk); n++; end while (!rep_valid && n < 100);
        mask = rep_grant;
    endtask

    task automatic result(int rid, int root);
        res_valid = 1'b1; res_rid = RIDW'(rid); res_root = PW'(root);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    initial begin
        int n;
        logic [MJ-1:0] mask;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports.
        chk("R1 req_ready", req_ready, 1);
        chk("R1 rep_valid", rep_valid, 0);
        chk("R1 xfer_valid", xfer_valid, 0);
        chk("R1 ret_valid", ret_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: empty family is replied at once with an all-zero mask (R4).
        clear_jobs(); send(7);
        wait_rep(n, mask);
        chk("R8 empty reply latency", n, 1);
        chk("R4 empty full refusal", mask, 0);

        // R5, R6: four forks, sizes 10,50,30,50 -> all granted, reply after 5.
        clear_jobs();
        set_job(0, 1, 0, 10, 'h100); set_job(1, 1, 0, 50, 'h101);
        set_job(2, 1, 0, 30, 'h102); set_job(3, 1, 0, 50, 'h103);
        send(0);
        wait_rep(n, mask);
        chk("R8 four-job reply latency", n, 5);
        chk("R6 mask all granted", mask, 4'b1111);
        chk("R6 smallest job lands on PE1", rep_pe[0 +: PEW], 1);
        chk("R5 first large job on PE0", rep_pe[1*PEW +: PEW], 0);

        // R3, R7: oversize fork refused, join with full home PE refused.
        clear_jobs();
        set_job(0, 1, 0, 255, 'h200); set_job(1, 0, 0, 5, 'h201);
        set_job(2, 0, 2, 20, 'h202); set_job(3, 1, 0, 5, 'h203);
        send(3);
        // R2: a stray request while deciding must not disturb anything.
        req_valid = 1'b1; @(negedge clk); req_valid = 1'b0;
        wait_rep(n, mask);
        chk("R3 R7 mixed mask", mask, 4'b1100);
        chk("R7 join placed on home PE2", rep_pe[2*PEW +: PEW], 2);

        // R9: result from busy reducer 1 returns to requester 0; free one ignored.
        result(1, 'h3a1);
        chk("R9 ret_dst to requester", ret_dst, 0);
        result(6, 'h3a6);
        chk("R9 free reducer ignored", ret_valid, 0);

        // R7: join homed on PE0 now fits on freed reducer 1.
        clear_jobs(); set_job(0, 0, 0, 50, 'h400);
        send(2);
        wait_rep(n, mask);
        chk("R7 join granted at home", mask, 4'b0001);

        // R10: exact fill of PE3 granted, one more node refused.
        clear_jobs(); set_job(0, 1, 0, 1, 'h500); set_job(1, 1, 0, 200, 'h501);
        send(4);
        wait_rep(n, mask);
        chk("R10 exact fit then overflow", mask, 4'b0010);
        chk("R10 exact fit on PE3", rep_pe[1*PEW +: PEW], 3);

        // Mixed traffic against the model.
        for (int it = 0; it < 40; it++) begin
            if ($urandom_range(0, 1) == 0) begin
                result($urandom_range(0, NRED - 1), $urandom_range(0, 65535));
            end else begin
                clear_jobs();
                for (int i = 0; i < MJ; i++)
                    if ($urandom_range(0, 3) != 0)
                        set_job(i, $urandom_range(0, 1), $urandom_range(0, NUM_PE - 1),
                                $urandom_range(1, 120), $urandom_range(0, 65535));
                send($urandom_range(0, NRED - 1));
                wait_rep(n, mask);
            end
        end
        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule